// File: doc/BRIEF.md
# USB IN Endpoint NAK Flag Register

This block sits beside the serial interface engine of a USB device controller. It records, for each of five IN endpoints, whether the endpoint's transmit FIFO holds a packet that is ready to go. It answers every IN token with either "send data" (ACK path) or NAK. Firmware arms an endpoint by writing that endpoint's transfer-size register, which the block sees as a one-cycle strobe. The endpoint stays armed until the host acknowledges the packet. After that, IN tokens to it are NAKed again until firmware re-arms it.

Each time a token is NAKed because the FIFO was not armed, the block sets a sticky per-endpoint flag in an 8-bit register that the CPU can read and write. The CPU clears a flag by writing 0 to its bit. Writing 1 leaves the bit unchanged. An interrupt line is raised when any set flag has its enable bit set.

In paired mode, FIFOs 0/1 and 2/3 act as pairs. Only the odd flag of each pair is live, and it collects NAKs from both members of the pair. Endpoint 4 has no partner and stays independent.

Top module: `usb_in_nak_status`

## Requirements
- R1: After reset the flag register reads 0x00, no endpoint is armed, `resp_valid` is 0 and `irq` is 0.
- R2: An IN token with endpoint number below 5 produces exactly one response. `resp_valid` is high in the cycle after the token, and `resp_ack` is 1 for data or 0 for NAK.
- R3: A token to an endpoint that is not armed is NAKed, and it sets that endpoint's flag (bit n for endpoint n), which is visible on `cpu_rdata` in the cycle after the token.
- R4: A size-register strobe arms its endpoint from the next cycle on, and tokens to an armed endpoint are ACKed without touching the flags. A token in the same cycle as the strobe still sees the endpoint as not armed.
- R5: A host handshake for an endpoint disarms it, so the following token to it is NAKed. If a size strobe for the same endpoint arrives in the same cycle, the strobe wins.
- R6: A CPU write clears each flag bit (bits 4..0) whose written value is 0. Bits written as 1 keep their value. Bits 7..5 always read 0.
- R7: When a NAK and a CPU clear-write hit the same flag bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some flag bit n is set while `irq_en[n]` is 1.
- R9: While `pair_mode` is 1, flag bits 0 and 2 read 0 from the cycle after the mode took effect. A NAK on endpoint 0 or 1 sets bit 1, a NAK on endpoint 2 or 3 sets bit 3, and endpoint 4 uses bit 4.
- R10: A token whose endpoint number is 5 or above gets no response and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_wr | input | 5 | Per-endpoint strobe: firmware wrote the transfer-size register |
| hs_valid | input | 1 | Host acknowledged the packet sent on `hs_ep` |
| hs_ep | input | 3 | Endpoint of the acknowledged packet |
| in_tok_valid | input | 1 | IN token received from the serial engine |
| in_tok_ep | input | 3 | Endpoint addressed by the token |
| resp_valid | output | 1 | Response to the previous cycle's token is present |
| resp_ack | output | 1 | 1 = send data, 0 = NAK |
| pair_mode | input | 1 | FIFO pairing enable |
| cpu_wr | input | 1 | CPU write strobe to the flag register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Flag register contents |
| irq_en | input | 5 | Per-endpoint interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
A wrong armed bit shows up at the next IN token to that endpoint, one cycle later, as a response of the wrong kind. A wrong flag bit shows up on `cpu_rdata` and possibly `irq` in the cycle after the event that caused it. Each response is matched in order against a queue of expected answers built from a model of the arming state. The bench also checks the flag register after every event, so a lost set, a wrong clear or a wrongly routed paired flag is caught within one cycle of its cause.

// File: rtl/usb_nak_pkg.sv
// Package: shared sizes and the pairing helper used by the NAK status block.
// Assumes endpoints are numbered from 0 and pairs are formed as (2k, 2k+1).
package usb_nak_pkg;
    localparam int unsigned NUM_EP_DEF = 5;
    localparam int unsigned EP_W_DEF   = 3;
    localparam int unsigned REG_W_DEF  = 8;

    // True when endpoint idx is the even member of a complete pair.
    function automatic bit is_even_paired(input int unsigned idx, input int unsigned n_ep);
        return ((idx % 2) == 0) && ((idx + 1) < n_ep);
    endfunction

    // True when endpoint idx is the odd member of a pair.
    function automatic bit is_odd_paired(input int unsigned idx);
        return (idx % 2) == 1;
    endfunction
endpackage

// File: rtl/nak_ready_arm.sv
// Module: per-endpoint "FIFO armed" bits.
// A size-register strobe arms an endpoint. A host handshake disarms it.
// The strobe has priority when both hit the same endpoint in one cycle.
// Assumes hs_ep values at or above NUM_EP touch nothing.
module nak_ready_arm #(
    parameter int unsigned NUM_EP = usb_nak_pkg::NUM_EP_DEF,
    parameter int unsigned EP_W   = usb_nak_pkg::EP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] size_wr,
    input  logic              hs_valid,
    input  logic [EP_W-1:0]   hs_ep,
    output logic [NUM_EP-1:0] armed
);
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic hs_hit;

        // Decode whether the handshake targets this endpoint.
        always_comb hs_hit = hs_valid && (hs_ep == EP_W'(e));

        // Hold the armed state: set by a size write, cleared by a handshake.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed[e] <= 1'b0;
            end else if (size_wr[e]) begin
                armed[e] <= 1'b1;
            end else if (hs_hit) begin
                armed[e] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nak_in_responder.sv
// Module: answers IN tokens and reports NAK events per endpoint.
// The response is registered, so it appears one cycle after the token.
// A token to an endpoint number at or above NUM_EP gets no response.
// Assumes at most one token per cycle.
module nak_in_responder #(
    parameter int unsigned NUM_EP = usb_nak_pkg::NUM_EP_DEF,
    parameter int unsigned EP_W   = usb_nak_pkg::EP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_tok_valid,
    input  logic [EP_W-1:0]   in_tok_ep,
    input  logic [NUM_EP-1:0] armed,
    output logic [NUM_EP-1:0] nak_hit,
    output logic              resp_valid,
    output logic              resp_ack
);
    logic tok_in_range;
    logic sel_armed;

    // Qualify the token and pick the armed bit of the addressed endpoint.
    always_comb begin
        tok_in_range = in_tok_valid && (32'(in_tok_ep) < NUM_EP);
        sel_armed    = 1'b0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (in_tok_ep == EP_W'(e)) sel_armed = armed[e];
        end
    end

    // One NAK-event line per endpoint, used by the flag bank.
    for (genvar e = 0; e < NUM_EP; e++) begin : g_hit
        always_comb nak_hit[e] = in_tok_valid && (in_tok_ep == EP_W'(e)) && !armed[e];
    end

    // Register the response toward the serial engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_ack   <= 1'b0;
        end else begin
            resp_valid <= tok_in_range;
            resp_ack   <= tok_in_range && sel_armed;
        end
    end
endmodule

// File: rtl/nak_flag_bank.sv
// Module: the sticky NAK flag register.
// A CPU write clears each flag bit written as 0. A NAK set beats a clear
// in the same cycle. In paired mode the even flag of each pair is held
// at 0 and its NAKs go to the odd flag. Bits at or above NUM_EP are
// constant 0.
module nak_flag_bank #(
    parameter int unsigned NUM_EP = usb_nak_pkg::NUM_EP_DEF,
    parameter int unsigned REG_W  = usb_nak_pkg::REG_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] nak_hit,
    input  logic              pair_mode,
    input  logic              cpu_wr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  flags
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i >= NUM_EP) begin : g_rsvd
            // Reserved bit: reads 0 and ignores writes.
            always_comb flags[i] = 1'b0;
        end else begin : g_live
            localparam bit EVEN_P = usb_nak_pkg::is_even_paired(i, NUM_EP);
            localparam bit ODD_P  = usb_nak_pkg::is_odd_paired(i);
            logic set_ev;
            logic clr_ev;
            logic hold0;

            if (ODD_P) begin : g_odd
                // Odd flag collects its partner's NAKs in paired mode.
                always_comb set_ev = nak_hit[i] || (pair_mode && nak_hit[i-1]);
            end else begin : g_even
                // Even flag takes only its own NAKs, and none in paired mode.
                always_comb set_ev = nak_hit[i] && !(pair_mode && EVEN_P);
            end

            // Clear on a written 0. Even paired bits are held at 0 in paired mode.
            always_comb begin
                clr_ev = cpu_wr && !cpu_wdata[i];
                hold0  = pair_mode && EVEN_P;
            end

            // Flag state: set has priority over a CPU clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else if (hold0) begin
                    flags[i] <= 1'b0;
                end else if (set_ev) begin
                    flags[i] <= 1'b1;
                end else if (clr_ev) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/usb_in_nak_status.sv
// Module: top of the IN-endpoint readiness and NAK flag block.
// Joins the arming bits, the token responder and the flag bank.
// Raises irq when an enabled flag is set.
// Assumes the CPU read path is combinational from the flag register.
module usb_in_nak_status #(
    parameter int unsigned NUM_EP = usb_nak_pkg::NUM_EP_DEF,
    parameter int unsigned EP_W   = usb_nak_pkg::EP_W_DEF,
    parameter int unsigned REG_W  = usb_nak_pkg::REG_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] size_wr,
    input  logic              hs_valid,
    input  logic [EP_W-1:0]   hs_ep,
    input  logic              in_tok_valid,
    input  logic [EP_W-1:0]   in_tok_ep,
    output logic              resp_valid,
    output logic              resp_ack,
    input  logic              pair_mode,
    input  logic              cpu_wr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic [NUM_EP-1:0] irq_en,
    output logic              irq
);
    logic [NUM_EP-1:0] armed;
    logic [NUM_EP-1:0] nak_hit;
    logic [REG_W-1:0]  flags;

    nak_ready_arm #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_arm (
        .clk(clk), .rst_n(rst_n), .size_wr(size_wr),
        .hs_valid(hs_valid), .hs_ep(hs_ep), .armed(armed)
    );

    nak_in_responder #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .in_tok_valid(in_tok_valid),
        .in_tok_ep(in_tok_ep), .armed(armed), .nak_hit(nak_hit),
        .resp_valid(resp_valid), .resp_ack(resp_ack)
    );

    nak_flag_bank #(.NUM_EP(NUM_EP), .REG_W(REG_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .nak_hit(nak_hit), .pair_mode(pair_mode),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .flags(flags)
    );

    // Expose the flags and form the interrupt from the enabled ones.
    always_comb begin
        cpu_rdata = flags;
        irq       = |(flags[NUM_EP-1:0] & irq_en);
    end
endmodule

// File: rtl/usb_in_nak_status_chk.sv
// Checker: temporal properties of the NAK status block, bound to the top.
module usb_in_nak_status_chk #(
    parameter int unsigned NUM_EP = 5,
    parameter int unsigned EP_W   = 3,
    parameter int unsigned REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EP-1:0] size_wr,
    input logic              hs_valid,
    input logic [EP_W-1:0]   hs_ep,
    input logic              in_tok_valid,
    input logic [EP_W-1:0]   in_tok_ep,
    input logic              resp_valid,
    input logic              resp_ack,
    input logic              pair_mode,
    input logic [REG_W-1:0]  cpu_rdata,
    input logic              irq,
    input logic [NUM_EP-1:0] armed
);
    // R1: after reset the flags and the response read idle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cpu_rdata == '0) && !resp_valid && !irq);

    // R2: every in-range token gets a response in the next cycle.
    assert_token_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tok_valid && (32'(in_tok_ep) < NUM_EP)) |=> resp_valid);

    // R3: a NAK in unpaired mode leaves the endpoint's flag set.
    assert_nak_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tok_valid && (32'(in_tok_ep) < NUM_EP) && !pair_mode && !armed[in_tok_ep])
        |=> cpu_rdata[$past(in_tok_ep)]);

    // R4: a size strobe arms its endpoint on the next cycle.
    assert_size_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        size_wr[0] |=> armed[0]);

    // R5: a handshake without a strobe leaves the endpoint disarmed.
    assert_hs_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && (32'(hs_ep) < NUM_EP) && !size_wr[hs_ep]) |=> !armed[$past(hs_ep)]);

    // R6: reserved bits never read 1.
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[REG_W-1:NUM_EP] == '0);

    // R8: no set flag means no interrupt.
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdata == '0) |-> !irq);

    // R9: even paired flags stay 0 while paired mode holds.
    assert_pair_even_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && $past(pair_mode) && $past(rst_n)) |-> (!cpu_rdata[0] && !cpu_rdata[2]));

    // R10: an out-of-range token gets no response.
    assert_bad_ep_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tok_valid && (32'(in_tok_ep) >= NUM_EP)) |=> !resp_valid);
endmodule

bind usb_in_nak_status usb_in_nak_status_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .size_wr(size_wr), .hs_valid(hs_valid), .hs_ep(hs_ep),
    .in_tok_valid(in_tok_valid), .in_tok_ep(in_tok_ep), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .pair_mode(pair_mode), .cpu_rdata(cpu_rdata), .irq(irq),
    .armed(armed)
);

// File: tb/sim_usb_in_nak_status.sv
module sim_usb_in_nak_status;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] size_wr;
    logic       hs_valid;
    logic [2:0] hs_ep;
    logic       in_tok_valid;
    logic [2:0] in_tok_ep;
    logic       resp_valid;
    logic       resp_ack;
    logic       pair_mode;
    logic       cpu_wr;
    logic [7:0] cpu_wdata;
    logic [7:0] cpu_rdata;
    logic [4:0] irq_en;
    logic       irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_in_nak_status u0 (
        .clk(clk), .rst_n(rst_n), .size_wr(size_wr), .hs_valid(hs_valid), .hs_ep(hs_ep),
        .in_tok_valid(in_tok_valid), .in_tok_ep(in_tok_ep), .resp_valid(resp_valid),
        .resp_ack(resp_ack), .pair_mode(pair_mode), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq_en(irq_en), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected answer for each response the design gives.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2/R10: actual=unexpected response expected=none");
            end else begin
                bit e;
                e = exp_q.pop_front();
                if (resp_ack !== e) begin
                    n_fail++;
                    $display("FAIL R2/R4/R5: actual ack=%0b expected ack=%0b", resp_ack, e);
                end
            end
        end
    end

    // Driver: one token; pushes the expected answer when in range.
    task automatic token(input logic [2:0] ep, input bit exp_ack);
        in_tok_valid = 1'b1;
        in_tok_ep    = ep;
        if (ep < 5) exp_q.push_back(exp_ack);
        @(negedge clk);
        in_tok_valid = 1'b0;
    endtask

    task automatic arm(input int ep);
        size_wr = 5'(1 << ep);
        @(negedge clk);
        size_wr = '0;
    endtask

    task automatic hshake(input logic [2:0] ep);
        hs_valid = 1'b1;
        hs_ep    = ep;
        @(negedge clk);
        hs_valid = 1'b0;
    endtask

    task automatic cwrite(input logic [7:0] d);
        cpu_wr    = 1'b1;
        cpu_wdata = d;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; size_wr = '0; hs_valid = 1'b0; hs_ep = '0;
        in_tok_valid = 1'b0; in_tok_ep = '0; pair_mode = 1'b0;
        cpu_wr = 1'b0; cpu_wdata = '0; irq_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 flags", cpu_rdata, 8'h00);
        check("R1 resp", {7'b0, resp_valid}, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R3: unarmed endpoint 2 is NAKed and flag 2 sets
        token(3'd2, 1'b0);
        check("R3 flag2", cpu_rdata, 8'h04);

        // R4: arm endpoint 2, token ACKed, flags untouched
        arm(2);
        token(3'd2, 1'b1);
        check("R4 flags kept", cpu_rdata, 8'h04);

        // R4: strobe and token in the same cycle still NAKs (endpoint 3)
        size_wr = 5'b01000; in_tok_valid = 1'b1; in_tok_ep = 3'd3; exp_q.push_back(1'b0);
        @(negedge clk);
        size_wr = '0; in_tok_valid = 1'b0;
        check("R4 same-cycle nak", cpu_rdata, 8'h0C);
        token(3'd3, 1'b1);

        // R5: handshake disarms endpoint 2
        hshake(3'd2);
        token(3'd2, 1'b0);
        check("R5 nak after hs", cpu_rdata, 8'h0C);

        // R5: strobe and handshake together keep endpoint 3 armed
        size_wr = 5'b01000; hs_valid = 1'b1; hs_ep = 3'd3;
        @(negedge clk);
        size_wr = '0; hs_valid = 1'b0;
        token(3'd3, 1'b1);

        // R6: writing ones changes nothing; written zero clears
        cwrite(8'hFF);
        check("R6 write ones", cpu_rdata, 8'h0C);
        cwrite(8'hFB);
        check("R6 clear bit2", cpu_rdata, 8'h08);
        cwrite(8'h00);
        check("R6 clear all", cpu_rdata, 8'h00);

        // R7: set wins over a same-cycle clear on endpoint 0
        in_tok_valid = 1'b1; in_tok_ep = 3'd0; exp_q.push_back(1'b0);
        cpu_wr = 1'b1; cpu_wdata = 8'h00;
        @(negedge clk);
        in_tok_valid = 1'b0; cpu_wr = 1'b0;
        check("R7 set wins", cpu_rdata, 8'h01);

        // R8: interrupt follows the enable mask
        irq_en = 5'b11110;
        #1 check("R8 masked", {7'b0, irq}, 8'h00);
        irq_en = 5'b00001;
        #1 check("R8 enabled", {7'b0, irq}, 8'h01);
        @(negedge clk);

        // R10: out-of-range endpoint: no response, no flag change
        token(3'd6, 1'b0);
        @(negedge clk);
        check("R10 flags", cpu_rdata, 8'h01);
        check("R10 queue", 8'(exp_q.size()), 8'h00);

        // R9: entering paired mode clears even flag 0
        pair_mode = 1'b1;
        @(negedge clk);
        check("R9 even cleared", cpu_rdata, 8'h00);
        token(3'd0, 1'b0);
        check("R9 ep0 to bit1", cpu_rdata, 8'h02);
        token(3'd2, 1'b0);
        check("R9 ep2 to bit3", cpu_rdata, 8'h0A);
        token(3'd4, 1'b0);
        check("R9 ep4 own bit", cpu_rdata, 8'h1A);
        cwrite(8'hF5);
        check("R9 clear odd", cpu_rdata, 8'h10);

        @(negedge clk);
        check("R2 all answered", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule